// File: doc/BRIEF.md
# Staggered Nonce Dispatcher for Parallel Double-Hash Cores

This block is the control unit in front of a set of identical double-hash cores. It keeps one shared nonce counter and gives each core a start strobe at its own fixed offset inside a repeating launch period, so the cores never start together. Every start takes the current counter value, which the block then advances. The nonces handed out are therefore consecutive across all cores, and no core chooses its own. The cores return results some time later, each tagged with the nonce it worked on.

For each returned result the block looks at the leading bits of the final hash. If those bits are all zero, the tagged nonce goes out on a registered valid/nonce winner port. The hash itself is not reported. If two cores win in the same cycle, the lower-indexed one is reported first and the other waits in a single holding slot. A host work load clears the counter and any pending winners, and restarts the launch pattern. When the counter has handed out its last value the block stops launching and raises an exhausted flag until new work is loaded.

Top module: `nonce_dispatch`

## Requirements
- R1: After reset, and until `loadWork` is first asserted, `launchValid` and `winValid` are zero and `exhausted` is low.
- R2: If `loadWork` is high in cycle t, then bit k of `launchValid` is high exactly in cycles t+1+k*(PERIOD/NUM_CORES)+m*PERIOD (m = 0,1,...), as long as the block is not exhausted. At most one bit is high in any cycle.
- R3: `launchNonce` in a launch cycle equals the number of launches since the last `loadWork` (the first launch carries 0). The value is shared by all cores and is valid with any launch bit.
- R4: A result from core k is a winner when `resValid[k]` is high and its `resHashTop` slice `[k*TOP_W +: TOP_W]` is all zeros. One cycle later `winValid` pulses for one cycle, with `winNonce` equal to slice `[k*NONCE_W +: NONCE_W]` of `resNonce`. A slice that is not all zeros (even one with only bit 0 set), or one whose valid bit is low, gives no report.
- R5: `loadWork` during a run restarts the pattern: in the next cycle core 0 launches with nonce 0, whatever the previous phase and count were.
- R6: If several winners arrive in one cycle, the lowest-indexed is reported in the next cycle and the second-lowest in the cycle after; any others are dropped. If the holding slot is already full, the held winner is reported next and the lowest new winner takes the slot.
- R7: The launch that carries the all-ones nonce is the last one. From the next cycle `exhausted` is high and no launch occurs until `loadWork`, which clears `exhausted`.
- R8: `loadWork` discards the reported and held winners and any winner arriving in that cycle: in the next cycle `winValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadWork | input | 1 | New work loaded by the host; restarts the search |
| resValid | input | NUM_CORES | Per-core result valid |
| resNonce | input | NUM_CORES*NONCE_W | Per-core tagged nonce, core 0 in the low bits |
| resHashTop | input | NUM_CORES*TOP_W | Per-core leading hash bits, core 0 in the low bits |
| launchValid | output | NUM_CORES | One-cycle start strobe per core |
| launchNonce | output | NONCE_W | Nonce taken by the core that starts this cycle |
| winValid | output | 1 | Winning nonce is present |
| winNonce | output | NONCE_W | Winning nonce |
| exhausted | output | 1 | Nonce space used up; launches halted |

## Verification
A phase counter that is off by some amount shows up as a start strobe on the wrong core bit or in the wrong cycle, no later than one launch period after a load. A nonce counter that skips or fails to clear shows up in the next launch's `launchNonce`. A fault in the winner priority or holding slot shows up in `winValid`/`winNonce` within two cycles of a simultaneous hit. A fault in exhaustion is caught by running the bench's reduced nonce width all the way to the wrap and checking both the flag edge and the silence after it.

// File: rtl/nonce_dispatch_pkg.sv
package nonce_dispatch_pkg;
  // Strobes from the control to the datapath, one cycle each.
  typedef struct packed {
    logic clear;    // new work: reset counter and winner state
    logic advance;  // a core launched this cycle: bump the counter
  } dispStrobe_t;
endpackage

// File: rtl/nonce_dispatch_ctrl.sv
module nonce_dispatch_ctrl
  import nonce_dispatch_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int PERIOD    = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadWork,
  input  logic                 lastNonce,
  output logic [NUM_CORES-1:0] launchValid,
  output logic                 exhausted,
  output dispStrobe_t          strobe
);
  localparam int SLOT = PERIOD / NUM_CORES;
  localparam int PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [PH_W-1:0] phase;
  logic            running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= '0;
      running   <= 1'b0;
      exhausted <= 1'b0;
    end else if (loadWork) begin
      phase     <= '0;
      running   <= 1'b1;
      exhausted <= 1'b0;
    end else if (running) begin
      phase <= (phase == PH_W'(PERIOD - 1)) ? '0 : phase + PH_W'(1);
      if (strobe.advance && lastNonce) exhausted <= 1'b1;
    end
  end

  // Each core owns one fixed slot in the period.
  for (genvar k = 0; k < NUM_CORES; k++) begin : g_slot
    assign launchValid[k] = running && !exhausted && (phase == PH_W'(k * SLOT));
  end

  always_comb begin
    strobe.clear   = loadWork;
    strobe.advance = |launchValid;
  end
endmodule

// File: rtl/nonce_dispatch_count.sv
module nonce_dispatch_count
  import nonce_dispatch_pkg::*;
#(
  parameter int NONCE_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  dispStrobe_t        strobe,
  output logic [NONCE_W-1:0] nextNonce,
  output logic               lastNonce
);
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) nextNonce <= '0;
    else if (strobe.advance)   nextNonce <= nextNonce + NONCE_W'(1);
  end

  assign lastNonce = &nextNonce;
endmodule

// File: rtl/nonce_dispatch_arb.sv
module nonce_dispatch_arb
  import nonce_dispatch_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NONCE_W   = 32,
  parameter int TOP_W     = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dispStrobe_t                  strobe,
  input  logic [NUM_CORES-1:0]         resValid,
  input  logic [NUM_CORES*NONCE_W-1:0] resNonce,
  input  logic [NUM_CORES*TOP_W-1:0]   resHashTop,
  output logic                         winValid,
  output logic [NONCE_W-1:0]           winNonce
);
  logic [NUM_CORES-1:0] hit;
  logic                 hasFirst, hasSecond, heldValid;
  logic [NONCE_W-1:0]   firstNonce, secondNonce, heldNonce;

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_hit
    assign hit[k] = resValid[k] && (resHashTop[k*TOP_W +: TOP_W] == '0);
  end

  // Lowest and second-lowest winning core in this cycle.
  always_comb begin
    hasFirst    = 1'b0;
    hasSecond   = 1'b0;
    firstNonce  = '0;
    secondNonce = '0;
    for (int k = 0; k < NUM_CORES; k++) begin
      if (hit[k]) begin
        if (!hasFirst) begin
          hasFirst   = 1'b1;
          firstNonce = resNonce[k*NONCE_W +: NONCE_W];
        end else if (!hasSecond) begin
          hasSecond   = 1'b1;
          secondNonce = resNonce[k*NONCE_W +: NONCE_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      winValid  <= 1'b0;
      winNonce  <= '0;
      heldValid <= 1'b0;
      heldNonce <= '0;
    end else if (heldValid) begin
      winValid  <= 1'b1;
      winNonce  <= heldNonce;
      heldValid <= hasFirst;
      heldNonce <= firstNonce;
    end else begin
      winValid  <= hasFirst;
      winNonce  <= firstNonce;
      heldValid <= hasSecond;
      heldNonce <= secondNonce;
    end
  end
endmodule

// File: rtl/nonce_dispatch.sv
module nonce_dispatch
  import nonce_dispatch_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int PERIOD    = 64,
  parameter int NONCE_W   = 32,
  parameter int TOP_W     = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         loadWork,
  input  logic [NUM_CORES-1:0]         resValid,
  input  logic [NUM_CORES*NONCE_W-1:0] resNonce,
  input  logic [NUM_CORES*TOP_W-1:0]   resHashTop,
  output logic [NUM_CORES-1:0]         launchValid,
  output logic [NONCE_W-1:0]           launchNonce,
  output logic                         winValid,
  output logic [NONCE_W-1:0]           winNonce,
  output logic                         exhausted
);
  dispStrobe_t strobe;
  logic        lastNonce;

  nonce_dispatch_ctrl #(.NUM_CORES(NUM_CORES), .PERIOD(PERIOD)) uCtrl (
    .clk(clk), .rstN(rstN), .loadWork(loadWork), .lastNonce(lastNonce),
    .launchValid(launchValid), .exhausted(exhausted), .strobe(strobe)
  );

  nonce_dispatch_count #(.NONCE_W(NONCE_W)) uCount (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .nextNonce(launchNonce), .lastNonce(lastNonce)
  );

  nonce_dispatch_arb #(.NUM_CORES(NUM_CORES), .NONCE_W(NONCE_W), .TOP_W(TOP_W)) uArb (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .resValid(resValid), .resNonce(resNonce), .resHashTop(resHashTop),
    .winValid(winValid), .winNonce(winNonce)
  );
endmodule

// File: rtl/nonce_dispatch_chk.sv
module nonce_dispatch_chk #(
  parameter int NUM_CORES = 4,
  parameter int NONCE_W   = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 loadWork,
  input logic [NUM_CORES-1:0] launchValid,
  input logic [NONCE_W-1:0]   launchNonce,
  input logic                 winValid,
  input logic                 exhausted
);
  AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(launchValid)); // R2
  AST_NONCE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (|launchValid) && !loadWork |=> launchNonce == $past(launchNonce) + NONCE_W'(1)); // R3
  AST_NONCE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(|launchValid) && !loadWork |=> $stable(launchNonce)); // R3
  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    loadWork |=> (launchValid == NUM_CORES'(1)) && (launchNonce == '0)); // R5
  AST_EXHAUST_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    exhausted |-> launchValid == '0); // R7
  AST_EXHAUST_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(exhausted) |-> $past(|launchValid) && ($past(launchNonce) == '1)); // R7
  AST_LOAD_DROPS_WIN: assert property (@(posedge clk) disable iff (!rstN)
    loadWork |=> !winValid); // R8
endmodule

bind nonce_dispatch nonce_dispatch_chk #(.NUM_CORES(NUM_CORES), .NONCE_W(NONCE_W)) uChk (
  .clk(clk), .rstN(rstN), .loadWork(loadWork), .launchValid(launchValid),
  .launchNonce(launchNonce), .winValid(winValid), .exhausted(exhausted)
);

// File: tb/sim_nonce_dispatch.sv
module sim_nonce_dispatch;
  localparam int NC = 4;
  localparam int PER = 16;
  localparam int NW = 8;
  localparam int TW = 8;
  localparam int SLOT = PER / NC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadWork = 1'b0;
  logic [NC-1:0] resValid = '0;
  logic [NC*NW-1:0] resNonce = '0;
  logic [NC*TW-1:0] resHashTop = '0;
  logic [NC-1:0] launchValid;
  logic [NW-1:0] launchNonce;
  logic winValid;
  logic [NW-1:0] winNonce;
  logic exhausted;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  nonce_dispatch #(.NUM_CORES(NC), .PERIOD(PER), .NONCE_W(NW), .TOP_W(TW)) u0 (
    .clk(clk), .rstN(rstN), .loadWork(loadWork), .resValid(resValid),
    .resNonce(resNonce), .resHashTop(resHashTop), .launchValid(launchValid),
    .launchNonce(launchNonce), .winValid(winValid), .winNonce(winNonce),
    .exhausted(exhausted)
  );

  // Vector fields: valid[13:10] zero[9:6] firstV[5] firstCore[4:3] secondV[2] secondCore[1:0]
  localparam logic [13:0] VEC [0:7] = '{
    {4'b0001, 4'b0001, 1'b1, 2'd0, 1'b0, 2'd0},
    {4'b0010, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0},
    {4'b0100, 4'b0100, 1'b1, 2'd2, 1'b0, 2'd0},
    {4'b0101, 4'b0101, 1'b1, 2'd0, 1'b1, 2'd2},
    {4'b1010, 4'b1010, 1'b1, 2'd1, 1'b1, 2'd3},
    {4'b0000, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0},
    {4'b1000, 4'b1000, 1'b1, 2'd3, 1'b0, 2'd0},
    {4'b1110, 4'b0110, 1'b1, 2'd1, 1'b1, 2'd2}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Drive results: cores in 'valid' present tag, cores in 'zero' have zero top bits, others 8'h01.
  task automatic drive(input logic [NC-1:0] valid, input logic [NC-1:0] zero, input int tag);
    resValid = valid;
    for (int k = 0; k < NC; k++) begin
      resNonce[k*NW +: NW]   = NW'(tag * 16 + k);
      resHashTop[k*TW +: TW] = zero[k] ? '0 : TW'(1);
    end
  endtask

  task automatic clearRes();
    resValid = '0;
    resHashTop = '0;
  endtask

  initial begin
    #(5.0 * 100000);
    $display("FAIL watchdog run did not complete actual=0x0 expected=0x1");
    failures++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int launches;
    int lastAt;
    int stopAt;
    repeat (3) tick();
    rstN = 1'b1;

    // R1: idle after reset
    for (int i = 0; i < 20; i++) begin
      check(launchValid == '0 && !winValid && !exhausted, "R1", "idle outputs",
            {launchValid, winValid, exhausted}, 0);
      tick();
    end

    // R4/R6: vector table, block idle so only the arbiter acts
    for (int i = 0; i < 8; i++) begin
      logic [13:0] v;
      v = VEC[i];
      drive(v[13:10], v[9:6], i);
      tick();
      clearRes();
      check(winValid == v[5], "R4", "first winValid", winValid, v[5]);
      if (v[5]) check(winNonce == NW'(i * 16 + v[4:3]), "R4", "first winNonce",
                      winNonce, i * 16 + v[4:3]);
      tick();
      check(winValid == v[2], "R6", "second winValid", winValid, v[2]);
      if (v[2]) check(winNonce == NW'(i * 16 + v[1:0]), "R6", "second winNonce",
                      winNonce, i * 16 + v[1:0]);
      tick();
      check(!winValid, "R4", "pulse ends", winValid, 0);
    end

    // R6: holding slot full when a new winner arrives
    drive(4'b0011, 4'b0011, 9);
    tick();
    drive(4'b0100, 4'b0100, 10);
    check(winValid && winNonce == NW'(9 * 16 + 0), "R6", "held case first", winNonce, 9 * 16);
    tick();
    clearRes();
    check(winValid && winNonce == NW'(9 * 16 + 1), "R6", "held case second", winNonce, 9 * 16 + 1);
    tick();
    check(winValid && winNonce == NW'(10 * 16 + 2), "R6", "held case third", winNonce, 10 * 16 + 2);
    tick();
    check(!winValid, "R6", "held case drained", winValid, 0);

    // R8: load discards a held winner and a coinciding one
    drive(4'b0011, 4'b0011, 11);
    tick();
    drive(4'b1000, 4'b1000, 12);
    loadWork = 1'b1;
    tick();
    loadWork = 1'b0;
    clearRes();
    check(!winValid, "R8", "winners dropped on load", winValid, 0);

    // R2/R3: launch pattern over three periods following the load
    launches = 0;
    for (int j = 0; j < 3 * PER; j++) begin
      logic [NC-1:0] expL;
      expL = '0;
      if ((j % SLOT) == 0) expL[(j % PER) / SLOT] = 1'b1;
      check(launchValid == expL, "R2", "launch pattern", launchValid, expL);
      if (expL != '0) begin
        check(launchNonce == NW'(launches), "R3", "launch nonce", launchNonce, launches);
        launches++;
      end
      if (j == 0) check(!winValid, "R8", "still no winner", winValid, 0);
      tick();
    end

    // R5: restart mid-period
    repeat (6) tick();
    loadWork = 1'b1;
    tick();
    loadWork = 1'b0;
    check(launchValid == NC'(1) && launchNonce == '0, "R5", "restart core0 nonce0",
          {launchValid, launchNonce}, {4'b0001, 8'h00});
    tick();
    check(launchValid == '0 && launchNonce == NW'(1), "R5", "restart counter stepped",
          {launchValid, launchNonce}, {4'b0000, 8'h01});

    // R7: run to the wrap
    loadWork = 1'b1;
    tick();
    loadWork = 1'b0;
    launches = 0;
    lastAt = -1;
    stopAt = -1;
    for (int c = 0; c < 1200; c++) begin
      if (launchValid != '0) begin
        if (launchNonce != NW'(launches))
          check(1'b0, "R3", "wrap run nonce", launchNonce, launches);
        if (launchNonce == '1) lastAt = c;
        launches++;
      end
      if (exhausted && stopAt < 0) stopAt = c;
      tick();
    end
    check(launches == (1 << NW), "R7", "launch count to wrap", launches, 1 << NW);
    check(lastAt >= 0 && stopAt == lastAt + 1, "R7", "exhausted next cycle", stopAt, lastAt + 1);
    check(exhausted && launchValid == '0, "R7", "halted", {exhausted, launchValid}, 5'b10000);
    loadWork = 1'b1;
    tick();
    loadWork = 1'b0;
    check(!exhausted && launchValid == NC'(1) && launchNonce == '0, "R7", "load clears exhausted",
          {exhausted, launchValid, launchNonce}, {1'b0, 4'b0001, 8'h00});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule